// File: doc/BRIEF.md
# Condition-Flag Integer ALU

This block is a 32-bit integer arithmetic and logic unit that keeps the four condition flags (negative, zero, carry, overflow) in its own status register. A caller presents two operands, a 4-bit opcode, a set-flags request and the carry produced by an external shifter, all qualified by `op_valid`. The block registers the result and raises `result_valid` one cycle later. On the same edge the flags update when the operation asks for it. Compare and test operations always update the flags and never produce a result.

Subtraction treats carry as the inverse of a borrow. Subtract-with-carry therefore removes one extra unit when carry is clear, and add-with-carry adds the stored carry. Together these let wider words be built from chained 32-bit steps. A direct flag-write port overrides any update from an operation in the same cycle. The flags are visible in the top nibble of a 32-bit status word.

Top module: `flag_alu`

## Requirements
- R1: Opcodes are 0 ADD (A+B), 1 ADC (A+B+C), 2 SUB (A−B), 3 SBC (A−B−!C), 4 AND, 5 OR, 6 XOR, 7 BIC (A & ~B), 8 MOV (B), 9 MVN (~B). A valid operation with one of these opcodes puts its result on `result` and raises `result_valid` on the clock edge that samples it. Both are visible in the following cycle.
- R2: Whenever flags are updated from an operation, N equals bit 31 of the computed value, and Z is set exactly when all 32 bits of that value are zero.
- R3: For ADD, ADC and CMN, C is set when the unsigned sum is 2^32 or more, and V is the XOR of the carry into bit 31 and the carry out of bit 31. For example, 0x7B000000+0x30000000 gives 0xAB000000 with N=1, V=1, C=0.
- R4: For SUB, SBC and CMP, C is set when no borrow occurs, for example 0xC0000000−0x80000000. V signals a signed result outside the 32-bit range.
- R5: ADC adds the stored C as a carry in. SBC computes A−B when C=1 and A−B−1 when C=0. For both, C and V come from the full sum including that carry.
- R6: Opcodes 0 to 9 update the flags only when `set_flags` is 1. With `set_flags`=0, or with `op_valid`=0, the flags keep their value.
- R7: Opcodes 10 CMP (A−B), 11 CMN (A+B), 12 TST (A&B) and 13 TEQ (A^B) always update the flags. They leave `result` unchanged and give `result_valid`=0 in the following cycle.
- R8: Logical operations that update flags (4 to 9, 12, 13) load C from `shift_carry` and leave V unchanged.
- R9: `status_word` carries N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. Bits 27:0 are zero.
- R10: When `flag_wr_en` is 1, the flags load `flag_wr_nzcv` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V), both to set and to clear. This write wins over any update from an operation in the same cycle.
- R11: Synchronous reset clears the flags, `result` and `result_valid`.
- R12: Opcodes 14 and 15 are reserved. They change neither the flags nor the result, and give `result_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Qualifies opcode and operands this cycle |
| opcode | input | 4 | Operation select (encoding in R1, R7, R12) |
| set_flags | input | 1 | Request a flag update for opcodes 0 to 9 |
| operand_a | input | 32 | First operand |
| operand_b | input | 32 | Second operand |
| shift_carry | input | 1 | Carry out of the external shifter, used as C by logical operations |
| flag_wr_en | input | 1 | Direct flag write strobe |
| flag_wr_nzcv | input | 4 | Direct flag write value {N,Z,C,V} |
| result | output | 32 | Registered result of the last result-writing operation |
| result_valid | output | 1 | Result was written on the last edge |
| status_word | output | 32 | Flags in bits 31:28, zero below |

## Verification
Every effect of an operation shows one cycle after it is presented: the result, `result_valid` and the flags are all registered on the single edge that samples the inputs. The bench drives each operation on a falling edge, lets exactly one rising edge pass, and compares all three at the next falling edge, before new inputs take effect. The stimulus vectors run in a fixed order, so the stored carry and overflow are part of the expected values. This chain covers the ADC and SBC behaviour and the unchanged V of the logical operations. The write-priority, idle and reset cases follow the same one-edge rule.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int WORD_W   = 32;
    localparam int FLAG_CNT = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_BIC  = 4'd7,
        OP_MOV  = 4'd8,
        OP_MVN  = 4'd9,
        OP_CMP  = 4'd10,
        OP_CMN  = 4'd11,
        OP_TST  = 4'd12,
        OP_TEQ  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        LF_AND = 3'd0,
        LF_OR  = 3'd1,
        LF_XOR = 3'd2,
        LF_BIC = 3'd3,
        LF_MOV = 3'd4,
        LF_MVN = 3'd5
    } logic_fn_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ARITH = 2'd1,
        CLS_LOGIC = 2'd2
    } op_class_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        op_class_e cls;
        logic      subtract;
        logic      carry_from_flag;
        logic      fixed_cin;
        logic      writes_result;
        logic      forced_flags;
        logic_fn_e lfn;
    } op_ctrl_t;

    function automatic op_ctrl_t decode_op(input logic [3:0] code);
        op_ctrl_t d;
        d.cls             = CLS_NONE;
        d.subtract        = 1'b0;
        d.carry_from_flag = 1'b0;
        d.fixed_cin       = 1'b0;
        d.writes_result   = 1'b0;
        d.forced_flags    = 1'b0;
        d.lfn             = LF_AND;
        case (alu_op_e'(code))
            OP_ADD: begin d.cls = CLS_ARITH; d.writes_result = 1'b1; end
            OP_ADC: begin d.cls = CLS_ARITH; d.writes_result = 1'b1; d.carry_from_flag = 1'b1; end
            OP_SUB: begin d.cls = CLS_ARITH; d.writes_result = 1'b1; d.subtract = 1'b1; d.fixed_cin = 1'b1; end
            OP_SBC: begin d.cls = CLS_ARITH; d.writes_result = 1'b1; d.subtract = 1'b1; d.carry_from_flag = 1'b1; end
            OP_AND: begin d.cls = CLS_LOGIC; d.writes_result = 1'b1; d.lfn = LF_AND; end
            OP_OR:  begin d.cls = CLS_LOGIC; d.writes_result = 1'b1; d.lfn = LF_OR;  end
            OP_XOR: begin d.cls = CLS_LOGIC; d.writes_result = 1'b1; d.lfn = LF_XOR; end
            OP_BIC: begin d.cls = CLS_LOGIC; d.writes_result = 1'b1; d.lfn = LF_BIC; end
            OP_MOV: begin d.cls = CLS_LOGIC; d.writes_result = 1'b1; d.lfn = LF_MOV; end
            OP_MVN: begin d.cls = CLS_LOGIC; d.writes_result = 1'b1; d.lfn = LF_MVN; end
            OP_CMP: begin d.cls = CLS_ARITH; d.forced_flags = 1'b1; d.subtract = 1'b1; d.fixed_cin = 1'b1; end
            OP_CMN: begin d.cls = CLS_ARITH; d.forced_flags = 1'b1; end
            OP_TST: begin d.cls = CLS_LOGIC; d.forced_flags = 1'b1; d.lfn = LF_AND; end
            OP_TEQ: begin d.cls = CLS_LOGIC; d.forced_flags = 1'b1; d.lfn = LF_XOR; end
            default: d.cls = CLS_NONE;
        endcase
        return d;
    endfunction

    function automatic nzcv_t nzcv_from_bits(input logic [FLAG_CNT-1:0] bits);
        nzcv_t f;
        f.n = bits[3];
        f.z = bits[2];
        f.c = bits[1];
        f.v = bits[0];
        return f;
    endfunction

endpackage

// File: rtl/flag_alu_adder.sv
module flag_alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         subtract,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         carry_out,
    output logic         overflow
);
    localparam int LOW_W = W - 1;

    logic [W-1:0]   b_eff;
    logic [W:0]     full_sum;
    logic [LOW_W:0] low_sum;
    logic           carry_into_msb;

    always_comb begin
        b_eff          = subtract ? ~b : b;
        full_sum       = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        low_sum        = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
        carry_into_msb = low_sum[LOW_W];
        sum            = full_sum[W-1:0];
        carry_out      = full_sum[W];
        overflow       = carry_into_msb ^ full_sum[W];
    end
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] y
);
    always_comb begin
        case (fn)
            LF_AND:  y = a & b;
            LF_OR:   y = a | b;
            LF_XOR:  y = a ^ b;
            LF_BIC:  y = a & ~b;
            LF_MOV:  y = b;
            LF_MVN:  y = ~b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/flag_alu_status.sv
module flag_alu_status
    import flag_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  nzcv_t wr_flags,
    input  logic  upd_en,
    input  nzcv_t upd_flags,
    output nzcv_t flags_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (wr_en) begin
            flags_q <= wr_flags;
        end else if (upd_en) begin
            flags_q <= upd_flags;
        end
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        opcode,
    input  logic              set_flags,
    input  logic [DATA_W-1:0] operand_a,
    input  logic [DATA_W-1:0] operand_b,
    input  logic              shift_carry,
    input  logic              flag_wr_en,
    input  logic [3:0]        flag_wr_nzcv,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic [DATA_W-1:0] status_word
);
    localparam int PAD_W = DATA_W - FLAG_CNT;

    op_ctrl_t          ctrl;
    nzcv_t             flags_q;
    nzcv_t             next_flags;
    logic              adder_cin;
    logic [DATA_W-1:0] arith_val;
    logic              arith_cout;
    logic              arith_ovf;
    logic [DATA_W-1:0] logic_val;
    logic [DATA_W-1:0] op_val;
    logic              flag_upd;
    logic              res_write;
    logic [DATA_W-1:0] result_q;
    logic              valid_q;

    always_comb begin
        ctrl      = decode_op(opcode);
        adder_cin = ctrl.carry_from_flag ? flags_q.c : ctrl.fixed_cin;
    end

    flag_alu_adder #(.W(DATA_W)) u_adder (
        .a         (operand_a),
        .b         (operand_b),
        .subtract  (ctrl.subtract),
        .cin       (adder_cin),
        .sum       (arith_val),
        .carry_out (arith_cout),
        .overflow  (arith_ovf)
    );

    flag_alu_logic #(.W(DATA_W)) u_logic (
        .a  (operand_a),
        .b  (operand_b),
        .fn (ctrl.lfn),
        .y  (logic_val)
    );

    always_comb begin
        op_val       = (ctrl.cls == CLS_ARITH) ? arith_val : logic_val;
        next_flags.n = op_val[DATA_W-1];
        next_flags.z = (op_val == '0);
        if (ctrl.cls == CLS_ARITH) begin
            next_flags.c = arith_cout;
            next_flags.v = arith_ovf;
        end else begin
            next_flags.c = shift_carry;
            next_flags.v = flags_q.v;
        end
        flag_upd  = op_valid && (ctrl.cls != CLS_NONE) && (ctrl.forced_flags || set_flags);
        res_write = op_valid && ctrl.writes_result;
    end

    flag_alu_status u_status (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (flag_wr_en),
        .wr_flags  (nzcv_from_bits(flag_wr_nzcv)),
        .upd_en    (flag_upd),
        .upd_flags (next_flags),
        .flags_q   (flags_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= res_write;
            if (res_write) begin
                result_q <= op_val;
            end
        end
    end

    always_comb begin
        result       = result_q;
        result_valid = valid_q;
        status_word  = {flags_q, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [3:0]        opcode,
    input logic              set_flags,
    input logic              flag_wr_en,
    input logic [3:0]        flag_wr_nzcv,
    input logic [DATA_W-1:0] result,
    input logic              result_valid,
    input logic [DATA_W-1:0] status_word
);
    // R1
    res_valid_follows_op_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode <= 4'd9) |=> result_valid);

    // R2
    nz_match_result_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode <= 4'd9 && set_flags && !flag_wr_en)
        |=> (status_word[DATA_W-1] == result[DATA_W-1]) && (status_word[DATA_W-2] == (result == '0)));

    // R6
    idle_flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !flag_wr_en) |=> $stable(status_word));

    // R7
    compare_no_result_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode >= 4'd10 && opcode <= 4'd13) |=> (!result_valid && $stable(result)));

    // R9
    status_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        status_word[DATA_W-5:0] == '0);

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        flag_wr_en |=> status_word[DATA_W-1:DATA_W-4] == $past(flag_wr_nzcv));

    // R12
    reserved_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode >= 4'd14 && !flag_wr_en)
        |=> ($stable(status_word) && $stable(result) && !result_valid));
endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) u_flag_alu_chk (
    .clk          (clk),
    .rst          (rst),
    .op_valid     (op_valid),
    .opcode       (opcode),
    .set_flags    (set_flags),
    .flag_wr_en   (flag_wr_en),
    .flag_wr_nzcv (flag_wr_nzcv),
    .result       (result),
    .result_valid (result_valid),
    .status_word  (status_word)
);

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 22;

    typedef struct packed {
        logic [3:0]  op;
        logic        sf;
        logic        shc;
        logic [31:0] a;
        logic [31:0] b;
        logic        ev;
        logic [31:0] er;
        logic [3:0]  ef;
    } vec_t;

    // Chained: each expected flag set depends on the ones before.
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  1'b1, 1'b0, 32'h7B000000, 32'h30000000, 1'b1, 32'hAB000000, 4'h9}, // R3 N,V set
        '{4'd0,  1'b1, 1'b0, 32'h7B000000, 32'hF0000000, 1'b1, 32'h6B000000, 4'h2}, // R3 carry
        '{4'd2,  1'b1, 1'b0, 32'hC0000000, 32'h80000000, 1'b1, 32'h40000000, 4'h2}, // R4 no borrow
        '{4'd3,  1'b1, 1'b0, 32'h7000BEEF, 32'h3000BABE, 1'b1, 32'h40000431, 4'h2}, // R5 chained high word
        '{4'd2,  1'b1, 1'b0, 32'h00000000, 32'h00000001, 1'b1, 32'hFFFFFFFF, 4'h8}, // R4 borrow
        '{4'd3,  1'b1, 1'b0, 32'h00000005, 32'h00000003, 1'b1, 32'h00000001, 4'h2}, // R5 C=0 extra one
        '{4'd1,  1'b1, 1'b0, 32'hFFFFFFFF, 32'h00000000, 1'b1, 32'h00000000, 4'h6}, // R5 ADC wrap, R2 Z
        '{4'd0,  1'b0, 1'b0, 32'h00000001, 32'h00000002, 1'b1, 32'h00000003, 4'h6}, // R6 no update
        '{4'd0,  1'b1, 1'b0, 32'h80000000, 32'h80000000, 1'b1, 32'h00000000, 4'h7}, // R3 neg ovf
        '{4'd5,  1'b1, 1'b0, 32'h80000000, 32'h00000001, 1'b1, 32'h80000001, 4'h9}, // R8 V kept
        '{4'd10, 1'b0, 1'b0, 32'h00000005, 32'h00000005, 1'b0, 32'h00000000, 4'h6}, // R7 CMP
        '{4'd11, 1'b0, 1'b0, 32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h00000000, 4'h9}, // R7 CMN
        '{4'd12, 1'b0, 1'b1, 32'h000000FF, 32'h00000100, 1'b0, 32'h00000000, 4'h7}, // R7 TST
        '{4'd13, 1'b0, 1'b0, 32'h80000000, 32'h00000000, 1'b0, 32'h00000000, 4'h9}, // R7 TEQ
        '{4'd6,  1'b0, 1'b0, 32'hFFFF0000, 32'h0000FFFF, 1'b1, 32'hFFFFFFFF, 4'h9}, // R6 XOR no flags
        '{4'd9,  1'b1, 1'b1, 32'h00000000, 32'h00000000, 1'b1, 32'hFFFFFFFF, 4'hB}, // R8 MVN
        '{4'd7,  1'b1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'h00000000, 4'h5}, // R8 BIC
        '{4'd8,  1'b1, 1'b0, 32'h00000000, 32'h12345678, 1'b1, 32'h12345678, 4'h1}, // R8 MOV
        '{4'd4,  1'b1, 1'b1, 32'hF0F0F0F0, 32'h0F0F0F0F, 1'b1, 32'h00000000, 4'h7}, // R8 AND
        '{4'd3,  1'b1, 1'b0, 32'h00000000, 32'h00000000, 1'b1, 32'h00000000, 4'h6}, // R5 SBC C=1
        '{4'd1,  1'b1, 1'b0, 32'h7FFFFFFF, 32'h00000000, 1'b1, 32'h80000000, 4'h9}, // R5 ADC ovf
        '{4'd3,  1'b1, 1'b0, 32'h80000000, 32'h00000000, 1'b1, 32'h7FFFFFFF, 4'h3}  // R5 SBC ovf
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  opcode;
    logic        set_flags;
    logic [31:0] operand_a;
    logic [31:0] operand_b;
    logic        shift_carry;
    logic        flag_wr_en;
    logic [3:0]  flag_wr_nzcv;
    logic [31:0] result;
    logic        result_valid;
    logic [31:0] status_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_alu dut (
        .clk          (clk),
        .rst          (rst),
        .op_valid     (op_valid),
        .opcode       (opcode),
        .set_flags    (set_flags),
        .operand_a    (operand_a),
        .operand_b    (operand_b),
        .shift_carry  (shift_carry),
        .flag_wr_en   (flag_wr_en),
        .flag_wr_nzcv (flag_wr_nzcv),
        .result       (result),
        .result_valid (result_valid),
        .status_word  (status_word)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_idle();
        op_valid = 1'b0; opcode = 4'd0; set_flags = 1'b0;
        operand_a = '0; operand_b = '0; shift_carry = 1'b0;
        flag_wr_en = 1'b0; flag_wr_nzcv = 4'h0;
    endtask

    task automatic drive_op(input logic [3:0] op, input logic sf, input logic shc,
                            input logic [31:0] a, input logic [31:0] b);
        op_valid = 1'b1; opcode = op; set_flags = sf; shift_carry = shc;
        operand_a = a; operand_b = b; flag_wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        drive_idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check32("R11 result", result, 32'h0);
        check32("R11 valid", {31'b0, result_valid}, 32'h0);
        check32("R11 status", status_word, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            drive_op(VECS[i].op, VECS[i].sf, VECS[i].shc, VECS[i].a, VECS[i].b);
            @(negedge clk);
            check32($sformatf("R1 vec%0d valid", i), {31'b0, result_valid}, {31'b0, VECS[i].ev});
            if (VECS[i].ev)
                check32($sformatf("R1 vec%0d result", i), result, VECS[i].er);
            check32($sformatf("R2/R9 vec%0d status", i), status_word, {VECS[i].ef, 28'h0});
        end
        // flags now 0011, result 7FFFFFFF

        // R12 reserved opcode is inert
        drive_op(4'd14, 1'b1, 1'b1, 32'h0, 32'h0);
        @(negedge clk);
        check32("R12 valid", {31'b0, result_valid}, 32'h0);
        check32("R12 result", result, 32'h7FFFFFFF);
        check32("R12 status", status_word, {4'h3, 28'h0});

        // R10 direct write beats a flag-setting add in the same cycle
        drive_op(4'd0, 1'b1, 1'b0, 32'h1, 32'h1);
        flag_wr_en = 1'b1; flag_wr_nzcv = 4'hC;
        @(negedge clk);
        check32("R10 priority status", status_word, {4'hC, 28'h0});
        check32("R1 add with write result", result, 32'h2);

        // R10 direct write clears
        drive_idle();
        flag_wr_en = 1'b1; flag_wr_nzcv = 4'h0;
        @(negedge clk);
        check32("R10 clear status", status_word, 32'h0);

        // R6 op_valid low ignores operation and set_flags
        drive_idle();
        set_flags = 1'b1; opcode = 4'd2; operand_a = 32'h0; operand_b = 32'h1;
        @(negedge clk);
        check32("R6 idle valid", {31'b0, result_valid}, 32'h0);
        check32("R6 idle status", status_word, 32'h0);
        check32("R6 idle result", result, 32'h2);

        // R11 reset mid-run clears flags and result
        drive_idle();
        flag_wr_en = 1'b1; flag_wr_nzcv = 4'hF;
        @(negedge clk);
        check32("R10 set all", status_word, {4'hF, 28'h0});
        drive_idle();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check32("R11 mid status", status_word, 32'h0);
        check32("R11 mid result", result, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule